// File: doc/BRIEF.md
# ADC Power-Down and Start-Up Sequencer

This block governs the digital side of an audio converter as it leaves and re-enters power-down. An active-low power-down request arrives asynchronously. It is synchronized to the master clock and then passed through a glitch filter, so a short low spike changes nothing and a sustained low resets the block. Once the request is released, the block holds the section in internal power-down for a fixed number of master clocks. It then waits a few word-clock frames and runs an initialization that is measured in word-clock frames. Only after all of that does it let converted samples through.

The moment at which release takes effect depends on the clocking mode. When the converter owns its clocks (master), release follows the master clock directly. When the clocks are supplied from outside (slave), release waits for the active word-clock edge. That edge is the rising edge for left-justified framing and the falling edge for I2S framing. Every frame count in the sequence uses the same active edge. Until the sequence completes, every sample strobe is passed on with both channels forced to two's-complement zero. A valid flag goes high together with the first sample that is not forced. The flag drops at once when a power-down is confirmed.

Top module: `adc_startup_seq`

## Requirements
- R1: While `rst_n` is low, or once a power-down request has been confirmed, `pwr_down`=1, `filt_rst`=1, `out_valid`=0 and `out_l`=`out_r`=0.
- R2: A low on `pd_n` is ignored when it lasts fewer than FILT_CYC consecutive clock samples. For example, a 7-cycle low with FILT_CYC=16 leaves `out_valid`=1 and `pwr_down`=0.
- R3: A low on `pd_n` held for at least FILT_CYC clocks is confirmed as a power-down. Taking the clock edge that follows the low-going input as edge 1, `out_valid` falls and `pwr_down` rises after edge FILT_CYC+2. This holds even when a sample strobe is processed at that same edge.
- R4: In master mode (`master_mode`=1), `pwr_down` falls after edge WAKE_CYC+4, counting from the first clock edge after `pd_n` rises.
- R5: In slave mode (`master_mode`=0), the wake count of WAKE_CYC clocks starts at the first active word-clock edge seen after the synchronized release. The active edge is rising for `i2s_mode`=0 and falling for `i2s_mode`=1.
- R6: After the wake count, the block counts GAP_FRM active word-clock edges and then the initialization edges. It counts INIT_MST edges in master mode and INIT_SLV edges in slave mode. `init_run` is 1 only during the initialization count, and `out_valid` stays 0 throughout.
- R7: `out_stb` repeats `smp_stb` one clock later. Whenever `out_valid`=0, the channel data delivered with a strobe is zero.
- R8: The first `smp_stb` processed after the initialization count ends sets `out_valid`. In that same cycle, `out_l` and `out_r` carry the input sample.
- R9: A confirmed power-down during start-up aborts the sequence. The next release repeats the whole sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; samples every input |
| rst_n | input | 1 | Chip-level asynchronous reset, active low |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| master_mode | input | 1 | 1: release follows master clock; 0: release waits for word-clock edge |
| i2s_mode | input | 1 | 1: falling word-clock edge is active; 0: rising |
| wclk | input | 1 | Word clock, synchronous to `clk` |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| smp_l | input | DW | Left sample from the filter |
| smp_r | input | DW | Right sample from the filter |
| out_stb | output | 1 | Sample strobe, delayed one clock |
| out_l | output | DW | Left sample, zero while forced |
| out_r | output | DW | Right sample, zero while forced |
| out_valid | output | 1 | High from the first unforced sample on |
| pwr_down | output | 1 | Internal power-down active |
| filt_rst | output | 1 | Digital filter held in reset |
| init_run | output | 1 | Initialization count in progress |

## Verification
A confirmed power-down and a sample strobe can both arrive at the same clock edge. If that happens while samples are running, the trip must win: the sample is delivered with zero data and `out_valid` clears. The bench provokes this by dropping `pd_n` at a word-clock phase chosen so that the filter confirms the low exactly on the edge that processes a strobe. At that edge it expects `out_stb`=1, zero data and `out_valid`=0.

// File: rtl/adc_startup_seq.sv
module adc_startup_seq #(
  parameter int DW       = 24,
  parameter int FILT_CYC = 16,
  parameter int WAKE_CYC = 147456,
  parameter int GAP_FRM  = 4,
  parameter int INIT_MST = 4129,
  parameter int INIT_SLV = 4132
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_n,
  input  logic          master_mode,
  input  logic          i2s_mode,
  input  logic          wclk,
  input  logic          smp_stb,
  input  logic [DW-1:0] smp_l,
  input  logic [DW-1:0] smp_r,
  output logic          out_stb,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r,
  output logic          out_valid,
  output logic          pwr_down,
  output logic          filt_rst,
  output logic          init_run
);
  localparam int M1   = (WAKE_CYC > INIT_SLV) ? WAKE_CYC : INIT_SLV;
  localparam int M2   = (INIT_MST > GAP_FRM) ? INIT_MST : GAP_FRM;
  localparam int CMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int FW   = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] WAKE_END = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] GAP_END  = CW'(GAP_FRM - 1);
  localparam logic [CW-1:0] IM_END   = CW'(INIT_MST - 1);
  localparam logic [CW-1:0] IS_END   = CW'(INIT_SLV - 1);
  localparam logic [FW-1:0] FILT_END = FW'(FILT_CYC - 1);

  typedef enum logic [2:0] {S_OFF, S_ARM, S_WAKE, S_GAP, S_INIT, S_RUN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [FW-1:0] lo_cnt;
  logic          pd_m, pd_s, wc_q;

  wire trip   = !pd_s && (lo_cnt == FILT_END);
  wire fedge  = i2s_mode ? (!wclk && wc_q) : (wclk && !wc_q);
  wire run    = (st == S_RUN) && !trip;
  wire [CW-1:0] init_end = master_mode ? IM_END : IS_END;

  assign pwr_down = (st == S_OFF) || (st == S_ARM) || (st == S_WAKE);
  assign filt_rst = (st == S_OFF);
  assign init_run = (st == S_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_m   <= 1'b0;
      pd_s   <= 1'b0;
      wc_q   <= 1'b0;
      lo_cnt <= '0;
    end else begin
      pd_m <= pd_n;
      pd_s <= pd_m;
      wc_q <= wclk;
      if (pd_s)       lo_cnt <= '0;
      else if (!trip) lo_cnt <= lo_cnt + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
    end else if (trip) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      case (st)
        S_OFF:  if (pd_s) st <= S_ARM;
        S_ARM:  if (master_mode || fedge) begin
                  st  <= S_WAKE;
                  cnt <= '0;
                end
        S_WAKE: if (cnt == WAKE_END) begin
                  st  <= S_GAP;
                  cnt <= '0;
                end else cnt <= cnt + CW'(1);
        S_GAP:  if (fedge) begin
                  if (cnt == GAP_END) begin
                    st  <= S_INIT;
                    cnt <= '0;
                  end else cnt <= cnt + CW'(1);
                end
        S_INIT: if (fedge) begin
                  if (cnt == init_end) begin
                    st  <= S_RUN;
                    cnt <= '0;
                  end else cnt <= cnt + CW'(1);
                end
        S_RUN:  st <= S_RUN;
        default: st <= S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_stb   <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_stb   <= smp_stb;
      out_l     <= run ? smp_l : '0;
      out_r     <= run ? smp_r : '0;
      out_valid <= run && (out_valid || smp_stb);
    end
  end
endmodule

module adc_startup_seq_chk #(parameter int DW = 24) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_down,
  input logic          filt_rst,
  input logic          init_run,
  input logic          out_valid,
  input logic          out_stb,
  input logic [DW-1:0] out_l,
  input logic [DW-1:0] out_r
);
  assert_pd_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!out_valid && out_l == '0 && out_r == '0));
  assert_filt_in_pd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    filt_rst |-> pwr_down);
  assert_init_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_run |-> (!out_valid && !pwr_down));
  assert_forced_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb && !out_valid) |-> (out_l == '0 && out_r == '0));
  assert_valid_on_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_stb);
endmodule

bind adc_startup_seq adc_startup_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .filt_rst(filt_rst),
  .init_run(init_run), .out_valid(out_valid), .out_stb(out_stb),
  .out_l(out_l), .out_r(out_r));

// File: tb/tb_adc_startup_seq.sv
`timescale 1ns/1ps
module tb_adc_startup_seq;
  localparam int DW = 24, FILT = 16, WAKE = 40, GAP = 3, INM = 9, INS = 12;

  logic clk = 0, rst_n = 0, pd_n = 0, master_mode = 1, i2s_mode = 0;
  logic wclk = 0, smp_stb = 0;
  logic [DW-1:0] smp_l = '0, smp_r = '0;
  logic out_stb, out_valid, pwr_down, filt_rst, init_run;
  logic [DW-1:0] out_l, out_r;
  logic [3:0] ph = 4'd0;
  int frc = 0, checks = 0, errors = 0;
  bit done = 0;

  adc_startup_seq #(.DW(DW), .FILT_CYC(FILT), .WAKE_CYC(WAKE), .GAP_FRM(GAP),
                    .INIT_MST(INM), .INIT_SLV(INS)) dut (.*);

  always #2 clk = ~clk;

  always @(negedge clk) begin
    ph = ph + 4'd1;
    wclk = ph[3];
    smp_stb = (ph == 4'd8);
    if (ph == 4'd8) begin
      frc++;
      smp_l = 24'h300000 + DW'(frc);
      smp_r = 24'h0A0000 + DW'(3 * frc);
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic smp();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 0; pd_n = 0;
    repeat (5) smp();
    @(negedge clk) rst_n = 1;
    repeat (3) smp();
    chk(pwr_down && filt_rst && !out_valid && out_l == '0 && out_r == '0,
        "R1 reset state", {pwr_down, filt_rst, out_valid}, 3'b110);
  endtask

  task automatic run_start(input bit mst, input bit i2s);
    int n = 0, fr = 0, forced = 0, badz = 0, initseen = 0, e;
    int hist[0:511];
    master_mode = mst; i2s_mode = i2s;
    smp();
    @(negedge clk) pd_n = 1;
    do begin
      smp(); n++; hist[n] = int'(ph);
    end while (pwr_down && n < 500);
    if (mst) chk(n == WAKE + 4, "R4 master wake length", n, WAKE + 4);
    else begin
      e = n - WAKE;
      chk(e >= 4 && hist[e] == (i2s ? 0 : 8), "R5 slave release edge",
          (e >= 4) ? hist[e] : -1, i2s ? 0 : 8);
    end
    n = 0;
    while (!out_valid && n < 2000) begin
      if (init_run) initseen++;
      if (out_stb) begin
        forced++;
        if (out_l != '0 || out_r != '0) badz++;
      end
      if (ph == (i2s ? 4'd15 : 4'd7)) fr++;
      smp(); n++;
    end
    chk(fr == GAP + (mst ? INM : INS) + (i2s ? 0 : 1), "R6 frame count", fr,
        GAP + (mst ? INM : INS) + (i2s ? 0 : 1));
    chk(initseen > 0, "R6 init_run seen", initseen, 1);
    chk(forced > 0 && badz == 0, "R7 forced zero samples", badz, 0);
    chk(out_valid && out_stb && out_l == smp_l && out_r == smp_r,
        "R8 first valid sample", int'(out_l), int'(smp_l));
    smp();
    while (!out_stb) smp();
    chk(out_valid && out_l == smp_l && out_r == smp_r, "R8 pass-through",
        int'(out_l), int'(smp_l));
  endtask

  task automatic t_glitch();
    int bad = 0;
    @(negedge clk) pd_n = 0;
    repeat (6) @(negedge clk);
    pd_n = 1;
    repeat (30) begin
      smp();
      if (!out_valid || pwr_down) bad++;
    end
    chk(bad == 0, "R2 short low ignored", bad, 0);
  endtask

  task automatic t_trip();
    int n = 0;
    do smp(); while (ph != 4'd6);
    @(negedge clk) pd_n = 0;
    do begin smp(); n++; end while (out_valid && n < 100);
    chk(n == FILT + 2, "R3 trip delay", n, FILT + 2);
    chk(out_stb && out_l == '0 && out_r == '0, "R3 trip beats strobe",
        int'(out_l), 0);
    chk(pwr_down && filt_rst, "R1 confirmed power-down", {pwr_down, filt_rst}, 3);
    repeat (4) smp();
  endtask

  task automatic t_abort();
    int n = 0, bad = 0;
    master_mode = 1; i2s_mode = 0;
    @(negedge clk) pd_n = 1;
    while (!init_run && n < 1000) begin smp(); n++; end
    chk(init_run, "R9 reached init", init_run, 1);
    @(negedge clk) pd_n = 0;
    repeat (FILT + 6) begin
      smp();
      if (out_valid) bad++;
    end
    chk(bad == 0 && pwr_down && !init_run, "R9 abort", {pwr_down, init_run}, 2);
    run_start(1, 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_start(1, 0);
    t_glitch();
    t_trip();
    run_start(0, 0);
    t_trip();
    run_start(0, 1);
    t_trip();
    t_abort();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule